// File: doc/BRIEF.md
# Shadow-Backed Static Memory with Sequence-Triggered Store and Recall

This block is a small word-addressed static memory with a nonvolatile shadow word behind every RAM word. The host reaches it through an SRAM-style port: active-low chip select, output enable and write enable, an address, and a data path. The path is split into a write bus, a read bus and a read-drive enable, which stands for the high-impedance control of a shared pin. Each enabled cycle is one access. In normal operation the block is plain read/write memory.

No dedicated pin starts a transfer. Instead, a watcher tracks the addresses of reads on the normal port. Reads of five fixed key addresses in order, followed by a sixth read, start a transfer. If the sixth address is the save command, the whole RAM is copied into the shadow (STORE). If it is the load command, the shadow is copied back into the RAM (RECALL). Any write, or any read that does not fit the expected step, throws the partial sequence away. Every read still returns ordinary RAM data.

During a transfer the `busy` output is high. Reads then get no drive, writes are dropped, and accesses are not seen by the watcher. A RECALL first clears every RAM word and then loads every word from the shadow. It never changes the shadow. A RECALL also runs on its own when reset is released.

The controller has four states:
- IDLE is the normal RAM mode.
- SAVE counts out the store time and copies the RAM into the shadow on its last cycle.
- CLEAR lasts one cycle and zeroes the RAM.
- LOAD counts out the rest of the recall time and copies the shadow into the RAM on its last cycle.

The transitions are:
- reset → CLEAR
- IDLE → SAVE on a completed save sequence
- IDLE → CLEAR on a completed load sequence
- CLEAR → LOAD always
- LOAD → IDLE when its count expires
- SAVE → IDLE when its count expires

Top module: `nvshadow_sram`

## Requirements
- R1: When `busy` is low and a cycle has `ce_n`=0, `we_n`=1 and `oe_n`=0, then `dq_oe` is 1 in that same cycle and `dq_out` equals the RAM word at `addr`. A cycle with `ce_n`=0 and `we_n`=0 writes `dq_in` into that word at the clock edge.
- R2: `dq_oe` is 0 in every cycle that is not an idle read with `oe_n`=0. This includes reads with `oe_n`=1 and the whole reset period.
- R3: Reset puts the block in RECALL. Counting from the first clock edge that sees `rst_n` high, `busy` stays high for exactly RECALL_CYCLES edges. After that the RAM holds the shadow contents.
- R4: Reads of KEY_A, KEY_B, KEY_C, KEY_D and KEY_E in that order, followed by a read of SAVE_CMD_ADDR, start a STORE. `busy` rises at the edge that ends that final read and stays high for exactly STORE_CYCLES cycles. The shadow then equals the whole RAM as it stood.
- R5: The same five key reads followed by a read of LOAD_CMD_ADDR start a RECALL. `busy` is high for exactly RECALL_CYCLES cycles, and every RAM word then equals its shadow word, which overwrites any writes made since the last STORE.
- R6: Reads that form part of a sequence, including the final command read, return normal RAM data with `dq_oe` high.
- R7: Each of the following discards the partial sequence, and no transfer follows:
  - a write at any step;
  - a read of a wrong address at any step;
  - a sixth read that is neither command address.

  Only a complete sequence that starts again from KEY_A then triggers a transfer.
- R8: While `busy` is high, reads give `dq_oe`=0, writes leave the RAM unchanged, and accesses do not advance the sequence watcher.
- R9: RECALL leaves the shadow unchanged, so back-to-back RECALLs give identical RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release starts a RECALL |
| ce_n | input | 1 | Chip select, active low; one access per selected cycle |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data, zero when not driven |
| dq_oe | output | 1 | Read-drive enable; low means the data pins float |
| busy | output | 1 | High while a STORE or RECALL runs |

## Verification
The bench builds the block with 16 words of 8 bits, a 40-cycle store and a 6-cycle recall. With only 16 words, every word can be written and read back around each transfer, so a copy that skips a word is caught. With short transfer times, exact busy lengths can be counted and many transfers fit in one run. These values also leave room for accesses that land inside a STORE, aborts at several different steps, and a second reset that must bring back previously stored data.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_CLEAR,
        XS_LOAD,
        XS_SAVE
    } xfer_state_e;

    localparam int KEY_LEN = 5;

endpackage

// File: rtl/nvs_seq_match.sv
module nvs_seq_match
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [KEY_LEN*ADDR_W-1:0] KEY_SEQ = '0,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = '1,
    parameter logic [ADDR_W-1:0] LOAD_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              go_save,
    output logic              go_load
);

    localparam int SW = $clog2(KEY_LEN + 1);

    logic [SW-1:0]     step;
    logic [ADDR_W-1:0] keys [KEY_LEN];
    logic              key_hit;
    logic              rd_acc;
    logic              at_last;

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_key
        assign keys[g] = KEY_SEQ[g*ADDR_W +: ADDR_W];
    end

    always_comb begin
        key_hit = 1'b0;
        for (int i = 0; i < KEY_LEN; i++) begin
            if (step == SW'(i) && acc_addr == keys[i]) key_hit = 1'b1;
        end
    end

    assign rd_acc  = acc_valid && !acc_write;
    assign at_last = (step == SW'(KEY_LEN));
    assign go_save = rd_acc && at_last && (acc_addr == SAVE_ADDR);
    assign go_load = rd_acc && at_last && (acc_addr == LOAD_ADDR);

    // Any access that is not the expected next key (including the command
    // read itself) returns the watcher to its first step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step <= '0;
        end else if (acc_valid) begin
            if (rd_acc && key_hit) step <= step + 1'b1;
            else                   step <= '0;
        end
    end

endmodule

// File: rtl/nvs_xfer_ctrl.sv
module nvs_xfer_ctrl
    import nvs_pkg::*;
#(
    parameter int STORE_CYCLES  = 40,
    parameter int RECALL_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_save,
    input  logic go_load,
    output logic busy,
    output logic do_clear,
    output logic do_load,
    output logic do_save
);

    localparam int CW = $clog2(STORE_CYCLES + 1);

    xfer_state_e   state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= XS_CLEAR;
            cnt   <= '0;
        end else begin
            unique case (state)
                XS_IDLE: begin
                    if (go_save) begin
                        state <= XS_SAVE;
                        cnt   <= CW'(STORE_CYCLES - 1);
                    end else if (go_load) begin
                        state <= XS_CLEAR;
                        cnt   <= '0;
                    end
                end
                XS_CLEAR: begin
                    state <= XS_LOAD;
                    cnt   <= CW'(RECALL_CYCLES - 2);
                end
                XS_LOAD, XS_SAVE: begin
                    if (cnt == '0) state <= XS_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != XS_IDLE);
        do_clear = (state == XS_CLEAR);
        do_load  = (state == XS_LOAD) && (cnt == '0);
        do_save  = (state == XS_SAVE) && (cnt == '0);
    end

endmodule

// File: rtl/nvs_cell_array.sv
module nvs_cell_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              do_clear,
    input  logic              do_load,
    input  logic              do_save,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram    [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];

    always_ff @(posedge clk) begin
        if (do_clear) begin
            for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
        end else if (do_load) begin
            ram <= shadow;
        end else if (wr_en) begin
            ram[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (do_save) shadow <= ram;
    end

    assign rdata = ram[addr];

endmodule

// File: rtl/nvshadow_sram.sv
module nvshadow_sram
    import nvs_pkg::*;
#(
    parameter int          ADDR_W        = 4,
    parameter int          DATA_W        = 8,
    parameter int          STORE_CYCLES  = 40,
    parameter int          RECALL_CYCLES = 6,
    parameter int unsigned KEY_A         = 3,
    parameter int unsigned KEY_B         = 12,
    parameter int unsigned KEY_C         = 5,
    parameter int unsigned KEY_D         = 10,
    parameter int unsigned KEY_E         = 6,
    parameter int unsigned SAVE_CMD_ADDR = 15,
    parameter int unsigned LOAD_CMD_ADDR = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              busy
);

    localparam logic [KEY_LEN*ADDR_W-1:0] KEY_SEQ = {
        ADDR_W'(KEY_E), ADDR_W'(KEY_D), ADDR_W'(KEY_C),
        ADDR_W'(KEY_B), ADDR_W'(KEY_A)
    };

    logic              port_ok;
    logic              go_save, go_load;
    logic              do_clear, do_load, do_save;
    logic [DATA_W-1:0] rdata;

    assign port_ok = !ce_n && !busy;

    nvs_seq_match #(
        .ADDR_W   (ADDR_W),
        .KEY_SEQ  (KEY_SEQ),
        .SAVE_ADDR(ADDR_W'(SAVE_CMD_ADDR)),
        .LOAD_ADDR(ADDR_W'(LOAD_CMD_ADDR))
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(port_ok),
        .acc_write(!we_n),
        .acc_addr (addr),
        .go_save  (go_save),
        .go_load  (go_load)
    );

    nvs_xfer_ctrl #(
        .STORE_CYCLES (STORE_CYCLES),
        .RECALL_CYCLES(RECALL_CYCLES)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_save (go_save),
        .go_load (go_load),
        .busy    (busy),
        .do_clear(do_clear),
        .do_load (do_load),
        .do_save (do_save)
    );

    nvs_cell_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_cells (
        .clk     (clk),
        .do_clear(do_clear),
        .do_load (do_load),
        .do_save (do_save),
        .wr_en   (port_ok && !we_n),
        .addr    (addr),
        .wdata   (dq_in),
        .rdata   (rdata)
    );

    assign dq_oe  = port_ok && we_n && !oe_n;
    assign dq_out = dq_oe ? rdata : '0;

endmodule

// File: rtl/nvs_checker.sv
module nvs_checker #(
    parameter int STORE_CYCLES  = 40,
    parameter int RECALL_CYCLES = 6
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic dq_oe,
    input logic busy
);

    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    p_busy_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dq_oe);

    p_drive_only_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && we_n && !oe_n));

    p_busy_from_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!ce_n && we_n));

    p_boot_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> busy);

    p_run_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_len != 0) |-> (run_len == RECALL_CYCLES || run_len == STORE_CYCLES));

endmodule

bind nvshadow_sram nvs_checker #(
    .STORE_CYCLES (STORE_CYCLES),
    .RECALL_CYCLES(RECALL_CYCLES)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .ce_n (ce_n),
    .oe_n (oe_n),
    .we_n (we_n),
    .dq_oe(dq_oe),
    .busy (busy)
);

// File: tb/sim_nvshadow_sram.sv
`timescale 1ns/1ps
module sim_nvshadow_sram;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int ST_CYC = 40;
    localparam int RC_CYC = 6;
    localparam int KEYS [5] = '{3, 12, 5, 10, 6};
    localparam int SAVE_A = 15;
    localparam int LOAD_A = 9;

    typedef struct {
        logic          oe;
        logic [DW-1:0] data;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, busy;

    int checks = 0;
    int fails  = 0;
    exp_t sbq [$];
    logic [DW-1:0] m_ram [DEPTH];
    logic [DW-1:0] m_sh  [DEPTH];

    always #2.5 clk = ~clk;

    nvshadow_sram #(
        .ADDR_W(AW), .DATA_W(DW), .STORE_CYCLES(ST_CYC), .RECALL_CYCLES(RC_CYC),
        .KEY_A(3), .KEY_B(12), .KEY_C(5), .KEY_D(10), .KEY_E(6),
        .SAVE_CMD_ADDR(SAVE_A), .LOAD_CMD_ADDR(LOAD_A)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    // Monitor: every read cycle pops one expected item from the scoreboard.
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !ce_n && we_n) begin
            checks++;
            if (sbq.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected read: oe=%0b data=%h expected no read", dq_oe, dq_out);
            end else begin
                e = sbq.pop_front();
                if (dq_oe !== e.oe || (e.oe && dq_out !== e.data)) begin
                    fails++;
                    $display("FAIL %s read: oe=%0b data=%h expected oe=%0b data=%h",
                             e.tag, dq_oe, dq_out, e.oe, e.data);
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, input logic exp_oe, input string tag);
        @(posedge clk); #1;
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(a);
        sbq.push_back('{exp_oe, m_ram[a], tag});
    endtask

    task automatic rd_nooe(input int a, input string tag);
        @(posedge clk); #1;
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = AW'(a);
        sbq.push_back('{1'b0, m_ram[a], tag});
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d, input bit upd);
        @(posedge clk); #1;
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(a); dq_in = d;
        if (upd) m_ram[a] = d;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic send_keys(input int n, input logic exp_oe, input string tag);
        for (int i = 0; i < n; i++) rd(KEYS[i], exp_oe, tag);
    endtask

    // Counts busy-high cycles of the next busy run (0 if none within the window).
    task automatic busy_len(output int n);
        idle();
        n = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (busy) n++;
            else if (n > 0) break;
        end
    endtask

    task automatic wait_idle();
        idle();
        for (int k = 0; k < 300 && busy; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic boot(input bit sh_known, input string tag);
        int n;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({tag, " busy in reset"}, int'(busy), 1);
        chk("R2 no drive in reset", int'(dq_oe), 0);
        rst_n = 1'b1;
        n = 1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
        chk({tag, " boot recall length"}, n, RC_CYC);
        if (sh_known) begin
            for (int i = 0; i < DEPTH; i++) m_ram[i] = m_sh[i];
            for (int i = 0; i < DEPTH; i++) rd(i, 1'b1, tag);
            idle();
        end
    endtask

    task automatic store_seq(input string tag);
        int n;
        send_keys(5, 1'b1, "R6");
        rd(SAVE_A, 1'b1, "R6");
        for (int i = 0; i < DEPTH; i++) m_sh[i] = m_ram[i];
        busy_len(n);
        chk({tag, " store busy length"}, n, ST_CYC);
    endtask

    task automatic recall_seq(input string tag);
        int n;
        send_keys(5, 1'b1, "R6");
        rd(LOAD_A, 1'b1, "R6");
        busy_len(n);
        chk({tag, " recall busy length"}, n, RC_CYC);
        for (int i = 0; i < DEPTH; i++) m_ram[i] = m_sh[i];
        for (int i = 0; i < DEPTH; i++) rd(i, 1'b1, tag);
        idle();
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report();
    end

    initial begin
        int n;
        // R3: power-up recall (shadow contents unknown the first time)
        boot(1'b0, "R3");

        // R1: fill and read back every word
        for (int i = 0; i < DEPTH; i++) wr(i, DW'(8'hA0 ^ (i * 7)), 1'b1);
        for (int i = 0; i < DEPTH; i++) rd(i, 1'b1, "R1");
        // R2: read with output enable off gives no drive
        rd_nooe(4, "R2");
        idle();

        // R4: store
        store_seq("R4");

        // R8: accesses during a store
        send_keys(5, 1'b1, "R6");
        rd(SAVE_A, 1'b1, "R6");
        rd(4, 1'b0, "R8");
        wr(2, 8'h55, 1'b0);
        send_keys(5, 1'b0, "R8");
        wait_idle();
        rd(LOAD_A, 1'b1, "R8");
        busy_len(n);
        chk("R8 keys during busy not counted", n, 0);
        rd(2, 1'b1, "R8");
        idle();

        // R5: overwrite RAM then recall
        for (int i = 0; i < DEPTH; i++) wr(i, DW'(8'h13 + i * 11), 1'b1);
        recall_seq("R5");
        // R9: second recall, same contents
        wr(7, 8'hEE, 1'b1);
        recall_seq("R9");

        // R7: abort by a write mid-sequence
        for (int i = 0; i < DEPTH; i++) wr(i, DW'(8'h5C ^ i), 1'b1);
        send_keys(3, 1'b1, "R6");
        wr(0, 8'h77, 1'b1);
        rd(KEYS[3], 1'b1, "R7");
        rd(KEYS[4], 1'b1, "R7");
        rd(SAVE_A, 1'b1, "R7");
        busy_len(n);
        chk("R7 write abort no busy", n, 0);
        // R7: abort by a wrong read
        send_keys(2, 1'b1, "R6");
        rd(0, 1'b1, "R7");
        rd(KEYS[2], 1'b1, "R7");
        rd(KEYS[3], 1'b1, "R7");
        rd(KEYS[4], 1'b1, "R7");
        rd(SAVE_A, 1'b1, "R7");
        busy_len(n);
        chk("R7 wrong read abort no busy", n, 0);
        // R7: sixth read not a command
        send_keys(5, 1'b1, "R6");
        rd(1, 1'b1, "R7");
        busy_len(n);
        chk("R7 non-command sixth read", n, 0);
        // R7: shadow untouched by aborts, recall shows the earlier store
        recall_seq("R7");
        // R7: full sequence after an abort still works
        wr(3, 8'h99, 1'b1);
        send_keys(2, 1'b1, "R6");
        rd(0, 1'b1, "R7");
        store_seq("R7");

        // R3: second power-up restores stored data
        for (int i = 0; i < DEPTH; i++) wr(i, 8'h00, 1'b1);
        idle();
        boot(1'b1, "R3");

        repeat (3) @(posedge clk);
        chk("R1 scoreboard drained", sbq.size(), 0);
        report();
    end

endmodule